// File: doc/BRIEF.md
# Cascadable Fall-Through Strobe FIFO

A first-in/first-out buffer of `DEPTH` words (64 by default) of `WIDTH` bits (4 or 5 in normal use). It uses strobes rather than read and write enables. A rising edge on `load_stb` stores the word on `data_in`. A rising edge on `unload_stb` discards the word currently shown on `data_out`. The oldest stored word always sits at the output without any request. `in_rdy` says that space is free, and `out_vld` says that `data_out` holds a real word. Both strobes are sampled in the `clk` domain through a two-register sampler and act on their rising edge only. A strobe held high therefore counts as one event.

The stream rules follow from that. `out_vld` acts as the valid and `unload_stb` as the consume strobe. `in_rdy` acts as the ready, and a strobe issued while it is low because the buffer is full changes nothing. The source must hold `data_in` steady from the rising edge of `load_stb` until `in_rdy` drops. After every accepted load, `in_rdy` falls for at least one cycle. After every accepted unload, `out_vld` falls for at least one cycle. These pulses give a neighbour an edge to react to. Two instances therefore chain directly for more depth: the downstream `in_rdy` drives the upstream `unload_stb`, the upstream `out_vld` drives the downstream `load_stb`, and the upstream `data_out` feeds the downstream `data_in`. For more width, parallel instances share strobes, and their `in_rdy` and `out_vld` flags are each combined with AND. `out_en_n` high releases `data_out` to high impedance.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds exactly `DEPTH` words. After `DEPTH` accepted loads with no unload, `in_rdy` is low.
- R2: Once settled, `in_rdy` is high exactly when fewer than `DEPTH` words are stored. It is low in the clock cycle that follows each accepted load.
- R3: Once settled, `out_vld` is high exactly when at least one word is stored. It is low in the clock cycle that follows each accepted unload.
- R4: A strobe rising between clock edges takes effect at the third rising clock edge after it. A word loaded into an empty buffer appears on `data_out` with `out_vld` high right after that edge, with no unload strobe.
- R5: Words leave in the order they were loaded. Each accepted unload exposes the next older word on `data_out`.
- R6: A load strobe while the buffer is full, or an unload strobe while it is empty, leaves the contents and flags unchanged.
- R7: Load and unload strobes that arrive together both take effect: one word leaves and one enters. When the buffer is empty only the load acts, and when it is full only the unload acts.
- R8: Reset (`rst_n` low, asynchronous) forces `out_vld` low, `in_rdy` high and `data_out` to all zeros. `data_out` reads zero whenever the buffer is empty and enabled.
- R9: With `out_en_n` high, `data_out` is high impedance. With `out_en_n` low, it drives the oldest word.
- R10: Two instances wired as a depth cascade deliver every word in load order at the downstream output.
- R11: A strobe held high for many cycles produces a single load or unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| load_stb | input | 1 | Rising edge stores `data_in` |
| data_in | input | WIDTH | Word to store |
| in_rdy | output | 1 | High when a word can be accepted |
| unload_stb | input | 1 | Rising edge removes the word on `data_out` |
| out_vld | output | 1 | High when `data_out` holds a stored word |
| out_en_n | input | 1 | Output enable, active low; high gives high impedance |
| data_out | output | WIDTH | Oldest stored word, zero when empty |

## Verification
The bench targets these corner cases:
- **Full and empty edges.** A design that lets a load through at full would overwrite the oldest word. One that honours an unload at empty would shift the pointers and later return stale data.
- **Simultaneous strobes at full and at empty.** A design that decides both from a stale count would grow, shrink or stall wrongly.
- **Flag pulses and held strobes.** A design that does not drop `in_rdy` or `out_vld` after an accept cannot be cascaded. One that acts on strobe level instead of the edge loads many copies from a single long strobe.
- **Two-instance cascade.** Lost or duplicated words show up as an order mismatch. This is the usual failure when the handshake pulse and the data capture are one cycle apart.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Register stages between a raw strobe pin and its edge decision.
  localparam int unsigned SAMPLE_STAGES = 2;

  // Bits needed to hold a fill count from 0 to depth inclusive.
  function automatic int unsigned fill_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // Bits needed to address depth words (at least one).
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/strobe_edge_sampler.sv
module strobe_edge_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  // pipe[STAGES-1] is the settled sample, pipe[STAGES] its previous value.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], strobe};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  // A held strobe gives one event only.
  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = fill_bits(DEPTH),
  localparam int unsigned PW = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (rd_en) rd_ptr <= step(rd_ptr);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  // Fall-through: the oldest word is always presented; zero when nothing stored.
  assign head  = empty ? '0 : mem[rd_ptr];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CW'(DEPTH)) || rd_en);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/strobe_fifo_flags.sv
module strobe_fifo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load_ev,
  input  logic unload_ev,
  input  logic full,
  input  logic empty,
  output logic wr_en,
  output logic rd_en,
  output logic in_rdy,
  output logic out_vld
);
  logic in_gap, out_gap;

  // Decisions use the state before the edge, so a simultaneous pair is safe.
  assign wr_en = load_ev & ~full;
  assign rd_en = unload_ev & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_gap  <= 1'b0;
      out_gap <= 1'b0;
    end else begin
      in_gap  <= wr_en;
      out_gap <= rd_en;
    end
  end

  assign in_rdy  = ~full  & ~in_gap;
  assign out_vld = ~empty & ~out_gap;

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !in_rdy);
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !out_vld);
  assert_ready_low_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_rdy);
  assert_valid_low_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !out_vld);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = fill_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_rdy,
  input  logic             unload_stb,
  output logic             out_vld,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] data_out
);
  // Index 0: load strobe, index 1: unload strobe.
  logic [1:0] raw_stb, stb_rise;
  assign raw_stb = {unload_stb, load_stb};

  for (genvar g = 0; g < 2; g++) begin : g_sampler
    strobe_edge_sampler #(.STAGES(SAMPLE_STAGES)) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (raw_stb[g]),
      .rise   (stb_rise[g])
    );
  end

  logic             wr_en, rd_en, full, empty;
  logic [WIDTH-1:0] head;
  logic [CW-1:0]    count;

  strobe_fifo_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ev   (stb_rise[0]),
    .unload_ev (stb_rise[1]),
    .full      (full),
    .empty     (empty),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .in_rdy    (in_rdy),
    .out_vld   (out_vld)
  );

  strobe_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (data_in),
    .rd_en   (rd_en),
    .head    (head),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  assign data_out = out_en_n ? 'z : head;

  assert_full_load_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise[0] && full && !rd_en) |=> (count == $past(count)));
  assert_empty_unload_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise[1] && empty && !wr_en) |=> (count == $past(count)));
  assert_pair_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> (count == $past(count)));
  assert_zero_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !out_en_n) |-> (data_out == '0));
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int W = 5;
  localparam int D = 64;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rst_n = 1'b0;
  logic         load = 1'b0, unload = 1'b0, oe_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         in_rdy, out_vld;
  wire  [W-1:0] dout;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u_strobe_fifo (
    .clk(clk), .rst_n(rst_n), .load_stb(load), .data_in(din), .in_rdy(in_rdy),
    .unload_stb(unload), .out_vld(out_vld), .out_en_n(oe_n), .data_out(dout)
  );

  // Depth cascade pair.
  logic         c_load = 1'b0, c_unload = 1'b0;
  logic [W-1:0] c_din = '0;
  logic         up_rdy, up_vld, dn_rdy, dn_vld;
  wire  [W-1:0] up_q, dn_q;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u_up (
    .clk(clk), .rst_n(rst_n), .load_stb(c_load), .data_in(c_din), .in_rdy(up_rdy),
    .unload_stb(dn_rdy), .out_vld(up_vld), .out_en_n(1'b0), .data_out(up_q)
  );
  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u_dn (
    .clk(clk), .rst_n(rst_n), .load_stb(up_vld), .data_in(up_q), .in_rdy(dn_rdy),
    .unload_stb(c_unload), .out_vld(dn_vld), .out_en_n(1'b0), .data_out(dn_q)
  );

  int total = 0, fails = 0;
  int model[$];

  function automatic int exp_rdy(input int n); return (n < D) ? 1 : 0; endfunction
  function automatic int exp_vld(input int n); return (n > 0) ? 1 : 0; endfunction
  function automatic int exp_head(); return (model.size() > 0) ? model[0] : 0; endfunction
  function automatic logic [W-1:0] cas_word(input int k); return W'((k * 7 + 3) % 32); endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_settled(input string req);
    check({req, " in_rdy"}, int'(in_rdy), exp_rdy(model.size()));
    check({req, " out_vld"}, int'(out_vld), exp_vld(model.size()));
    check({req, " data_out"}, int'(dout), exp_head());
  endtask

  // One strobe cycle: raise, let it act at the third edge, lower, settle.
  task automatic strobe(input bit do_w, input bit do_r, input logic [W-1:0] d, input bit full_check);
    int n = model.size();
    bit wacc = do_w && (n < D);
    bit racc = do_r && (n > 0);
    @(negedge clk);
    din = d; load = do_w; unload = do_r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (wacc) check("R2 ready pulse", int'(in_rdy), 0);
    if (racc) check("R3 valid pulse", int'(out_vld), 0);
    if (wacc && n == 0 && !do_r) begin
      check("R4 fall-through valid", int'(out_vld), 1);
      check("R4 fall-through word", int'(dout), int'(d));
    end
    if (racc) void'(model.pop_front());
    if (wacc) model.push_back(int'(d));
    load = 1'b0; unload = 1'b0;
    repeat (2) @(negedge clk);
    if (full_check) check_settled("R5 R7 settled");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reset out_vld", int'(out_vld), 0);
    check("R8 reset in_rdy", int'(in_rdy), 1);
    check("R8 reset data_out", int'(dout), 0);
    model.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R6: unload on empty is ignored.
    strobe(1'b0, 1'b1, '0, 1'b1);
    check("R6 empty unload", int'(out_vld), 0);

    // R4/R5: fall-through and order.
    strobe(1'b1, 1'b0, 5'd9, 1'b1);
    strobe(1'b1, 1'b0, 5'd17, 1'b1);
    strobe(1'b0, 1'b1, '0, 1'b1);
    check("R5 next word", int'(dout), 17);
    strobe(1'b0, 1'b1, '0, 1'b1);

    // R7: both strobes on empty -> only load acts.
    strobe(1'b1, 1'b1, 5'd21, 1'b1);
    check("R7 pair on empty", int'(out_vld), 1);
    strobe(1'b1, 1'b1, 5'd6, 1'b1);
    check("R7 pair swap", int'(dout), 6);
    strobe(1'b0, 1'b1, '0, 1'b1);

    // R11: held load produces one word.
    @(negedge clk);
    din = 5'd30; load = 1'b1;
    repeat (12) @(negedge clk);
    load = 1'b0;
    model.push_back(30);
    repeat (3) @(negedge clk);
    check_settled("R11 held load");
    strobe(1'b0, 1'b1, '0, 1'b1);
    check("R11 single word", int'(out_vld), 0);

    // R9: output enable.
    strobe(1'b1, 1'b0, 5'd13, 1'b0);
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    total++;
    if (dout !== {W{1'bz}}) begin
      fails++;
      $display("FAIL R9 disabled: got %b expected %b", dout, {W{1'bz}});
    end
    oe_n = 1'b0;
    @(negedge clk);
    check("R9 enabled drives", int'(dout), 13);
    strobe(1'b0, 1'b1, '0, 1'b1);

    // R1: fill to depth, then R6 overflow and R7 pair at full.
    for (int i = 0; i < D; i++) strobe(1'b1, 1'b0, W'(i), 1'b0);
    check_settled("R1 full");
    check("R1 full in_rdy", int'(in_rdy), 0);
    strobe(1'b1, 1'b0, 5'd31, 1'b1);
    check("R6 full load ignored", int'(dout), 0);
    strobe(1'b1, 1'b1, 5'd31, 1'b1);
    check("R7 pair on full", int'(in_rdy), 1);
    for (int i = 0; i < D; i++) strobe(1'b0, 1'b1, '0, 1'b0);
    check_settled("R5 drained");

    // Constrained random mix.
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom_range(0, 9));
      logic [W-1:0] d = W'($urandom);
      if (r < 5)      strobe(1'b1, 1'b0, d, 1'b1);
      else if (r < 8) strobe(1'b0, 1'b1, d, 1'b1);
      else            strobe(1'b1, 1'b1, d, 1'b1);
    end

    // R8: reset with content.
    do_reset();

    // R10: depth cascade.
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      c_din = cas_word(k); c_load = 1'b1;
      repeat (4) @(negedge clk);
      c_load = 1'b0;
      repeat (12) @(negedge clk);
    end
    repeat (300) @(negedge clk);
    for (int k = 0; k < 100; k++) begin
      check("R10 cascade valid", int'(dn_vld), 1);
      check("R10 cascade order", int'(dn_q), int'(cas_word(k)));
      c_unload = 1'b1;
      repeat (4) @(negedge clk);
      c_unload = 1'b0;
      repeat (16) @(negedge clk);
    end
    check("R10 cascade drained", int'(dn_vld), 0);

    summary();
    $finish;
  end
endmodule